// File: doc/BRIEF.md
# Bit-serial switch register access master

This block lets on-chip logic read and write the configuration registers and counters of an external switch device over three wires: a chip select, a serial clock and one shared data line. The host presents a request (write flag, table select, address, write data) on a valid/ready handshake. The block sends the serial frame, turns the data line around for reads, and collects the response. It then raises a one-cycle done pulse with the read data. Between transactions every pin has its output enable off, so the board can share or tri-state them.

The two directions use different frames. A write sends 27 bits with chip select high. The bits are a start bit of 1, the opcode 01, an 8-bit address and 16 data bits. Two extra clocks follow, with chip select low. A read keeps chip select low throughout. It sends a preamble of 32 ones, then 0 1 1 0, a table-select bit, a 7-bit address and two zeros. The block then releases the data line, gives two turnaround clocks and samples 32 bits, most significant first. Two trailing clocks end the read.

Serial timing comes from a system-clock divider derived from the parameters CLK_MHZ, PHASE_NS and SETUP_NS. Every clock-low and clock-high phase lasts the same number of system cycles, long enough for both the phase minimum and the data setup minimum.

The state machine has these states and transitions:

- IDLE: go to LEAD on an accepted request.
- LEAD: one phase with the outputs enabled and the clock low, then go to CMD_LO.
- CMD_LO and CMD_HI: alternate once per command bit. After the last bit, go from CMD_HI to CMD_END.
- CMD_END: a final clock-low phase. After it, a write goes to XTRA_HI and a read goes to TURN_HI.
- TURN_HI and TURN_LO: alternate for two clocks, then go to RD_LO.
- RD_LO and RD_HI: alternate for 32 sampled bits, then go to RD_END.
- RD_END: a clock-low phase, then go to XTRA_HI.
- XTRA_HI and XTRA_LO: alternate for two clocks, then go to FINISH.
- FINISH: one cycle with the done pulse, then go back to IDLE.

Top module: `swreg_serial_master`

## Requirements
- R1: Out of reset and whenever no transaction is in progress, req_ready is 1 and cs_oe, sck_oe and sd_oe are all 0.
- R2: A write sends exactly 27 command bits, most significant first, sampled at sck rising edges. The bits in order are 1, 0, 1, then req_addr[7:0], then req_wdata[15:0].
- R3: During a write, cs_o is 1 at each of the 27 command rising edges. It is 0 at the two extra rising edges that follow, and sd_oe stays 1 for all 29 edges.
- R4: During a read, cs_o stays 0 throughout. The first 46 rising edges carry 32 ones, then 0,1,1,0, then req_table, then req_addr[6:0] MSB first, then 0,0.
- R5: After the read command, sd_oe is 0 for the remaining 36 rising edges: 2 turnaround edges, then 32 data edges, then 2 trailing edges, for 82 edges in total. The master samples sd_i just before each data rising edge, and the first sampled bit is the response MSB.
- R6: For a read with table select 0, rsp_rdata is the 32-bit response shifted right by 16 when the address LSB is 1. When the LSB is 0, it is the low 16 bits of the response. The upper 16 bits of rsp_rdata are 0 in both cases.
- R7: For a read with table select 1, rsp_rdata is the full 32-bit response.
- R8: While sck_oe is 1, every sck low and high phase lasts at least the phase length in system cycles, ceil(CLK_MHZ*PHASE_NS/1000). sd_o, while driven, is stable for at least ceil(CLK_MHZ*SETUP_NS/1000) cycles before each rising edge.
- R9: req_ready is 0 while a transaction runs. A request held during that time is not taken and does not alter the running frame. It is taken only after done, and only if it is still valid.
- R10: rsp_done is a single-cycle pulse at the end of each transaction, with rsp_rdata valid in that cycle. For a write, rsp_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_table | input | 1 | Read table: 0 = 16-bit registers, 1 = 32-bit counters |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, valid with rsp_done |
| cs_o | output | 1 | Chip select value |
| cs_oe | output | 1 | Chip select output enable |
| sck_o | output | 1 | Serial clock value |
| sck_oe | output | 1 | Serial clock output enable |
| sd_o | output | 1 | Serial data out value |
| sd_oe | output | 1 | Serial data output enable |
| sd_i | input | 1 | Serial data in |

## Verification
The done pulse of one transaction and a host request can fall in the same cycle. The bench provokes this by raising a second request in the middle of a write and holding it through the done pulse. It then checks several things. req_ready stays low at every sample while the write runs. The write frame carries only the first request's fields. The held read then starts as a fresh transaction, with its own complete 82-edge frame and correct data. A request pulsed briefly during a transaction must leave no trace: the bench checks that no further clock edges appear and that the pins stay released afterwards.

// File: rtl/swm_pkg.sv
package swm_pkg;
    localparam int FRAME_W    = 46;
    localparam int WR_BITS    = 27;
    localparam int RD_BITS    = 46;
    localparam int RESP_W     = 32;
    localparam int TURN_CLKS  = 2;
    localparam int EXTRA_CLKS = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LEAD,
        S_CMD_LO,
        S_CMD_HI,
        S_CMD_END,
        S_TURN_HI,
        S_TURN_LO,
        S_RD_LO,
        S_RD_HI,
        S_RD_END,
        S_XTRA_HI,
        S_XTRA_LO,
        S_FINISH
    } swm_state_t;
endpackage

// File: rtl/swm_phase_timer.sv
module swm_phase_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PHASE_CYC < 2) ? 1 : $clog2(PHASE_CYC);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(PHASE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/swm_frame_build.sv
module swm_frame_build
    import swm_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic               write,
    input  logic               table_sel,
    input  logic [7:0]         addr,
    input  logic [15:0]        wdata,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   last_idx
);
    localparam int WR_PAD = FRAME_W - WR_BITS;

    always_comb begin
        if (write) begin
            frame    = {1'b1, 2'b01, addr, wdata, {WR_PAD{1'b0}}};
            last_idx = CNT_W'(WR_BITS - 1);
        end else begin
            frame    = {{32{1'b1}}, 4'b0110, table_sel, addr[6:0], 2'b00};
            last_idx = CNT_W'(RD_BITS - 1);
        end
    end
endmodule

// File: rtl/swm_rsp_select.sv
module swm_rsp_select #(
    parameter int RESP_W = 32
) (
    input  logic              table_sel,
    input  logic              addr_lsb,
    input  logic [RESP_W-1:0] word,
    output logic [RESP_W-1:0] rdata
);
    localparam int HALF = RESP_W / 2;

    always_comb begin
        if (table_sel)
            rdata = word;
        else if (addr_lsb)
            rdata = {{HALF{1'b0}}, word[RESP_W-1:HALF]};
        else
            rdata = {{HALF{1'b0}}, word[HALF-1:0]};
    end
endmodule

// File: rtl/swreg_serial_master.sv
module swreg_serial_master
    import swm_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int PHASE_NS = 3000,
    parameter int SETUP_NS = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic        req_table,
    input  logic [7:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        rsp_done,
    output logic [31:0] rsp_rdata,
    output logic        cs_o,
    output logic        cs_oe,
    output logic        sck_o,
    output logic        sck_oe,
    output logic        sd_o,
    output logic        sd_oe,
    input  logic        sd_i
);
    localparam int PH_RAW    = (CLK_MHZ * PHASE_NS + 999) / 1000;
    localparam int SU_RAW    = (CLK_MHZ * SETUP_NS + 999) / 1000;
    localparam int PH_MAX    = (PH_RAW > SU_RAW) ? PH_RAW : SU_RAW;
    localparam int PHASE_CYC = (PH_MAX < 1) ? 1 : PH_MAX;
    localparam int CNT_W     = $clog2(FRAME_W);

    swm_state_t           state, nxt;
    logic                 cur_write, cur_table, cur_lsb;
    logic [FRAME_W-1:0]   sh;
    logic [RESP_W-1:0]    rd_sh;
    logic [CNT_W-1:0]     cnt;
    logic                 tick, run, accept;
    logic [FRAME_W-1:0]   load_frame;
    logic [CNT_W-1:0]     load_idx;

    assign accept = req_valid && (state == S_IDLE);
    assign run    = (state != S_IDLE) && (state != S_FINISH);

    swm_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    swm_frame_build #(.CNT_W(CNT_W)) u_frame (
        .write     (req_write),
        .table_sel (req_table),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .frame     (load_frame),
        .last_idx  (load_idx)
    );

    swm_rsp_select #(.RESP_W(RESP_W)) u_rsp (
        .table_sel (cur_table),
        .addr_lsb  (cur_lsb),
        .word      (rd_sh),
        .rdata     (rsp_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath: request latch, shifters, bit and clock counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_table <= 1'b0;
            cur_lsb   <= 1'b0;
            sh        <= '0;
            rd_sh     <= '0;
            cnt       <= '0;
        end else if (accept) begin
            cur_write <= req_write;
            cur_table <= req_table;
            cur_lsb   <= req_addr[0];
            sh        <= load_frame;
            rd_sh     <= '0;
            cnt       <= load_idx;
        end else if (tick) begin
            unique case (state)
                S_CMD_HI: if (cnt != '0) begin
                    sh  <= {sh[FRAME_W-2:0], 1'b0};
                    cnt <= cnt - 1'b1;
                end
                S_CMD_END: cnt <= cur_write ? CNT_W'(EXTRA_CLKS - 1) : CNT_W'(TURN_CLKS - 1);
                S_TURN_LO: cnt <= (cnt == '0) ? CNT_W'(RESP_W - 1) : cnt - 1'b1;
                S_RD_LO:   rd_sh <= {rd_sh[RESP_W-2:0], sd_i};
                S_RD_HI:   if (cnt != '0) cnt <= cnt - 1'b1;
                S_RD_END:  cnt <= CNT_W'(EXTRA_CLKS - 1);
                S_XTRA_LO: if (cnt != '0) cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (accept) nxt = S_LEAD;
            S_LEAD:    if (tick) nxt = S_CMD_LO;
            S_CMD_LO:  if (tick) nxt = S_CMD_HI;
            S_CMD_HI:  if (tick) nxt = (cnt == '0) ? S_CMD_END : S_CMD_LO;
            S_CMD_END: if (tick) nxt = cur_write ? S_XTRA_HI : S_TURN_HI;
            S_TURN_HI: if (tick) nxt = S_TURN_LO;
            S_TURN_LO: if (tick) nxt = (cnt == '0) ? S_RD_LO : S_TURN_HI;
            S_RD_LO:   if (tick) nxt = S_RD_HI;
            S_RD_HI:   if (tick) nxt = (cnt == '0) ? S_RD_END : S_RD_LO;
            S_RD_END:  if (tick) nxt = S_XTRA_HI;
            S_XTRA_HI: if (tick) nxt = S_XTRA_LO;
            S_XTRA_LO: if (tick) nxt = (cnt == '0) ? S_FINISH : S_XTRA_HI;
            S_FINISH:  nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        logic in_cmd;
        in_cmd    = (state == S_LEAD) || (state == S_CMD_LO) ||
                    (state == S_CMD_HI) || (state == S_CMD_END);
        req_ready = (state == S_IDLE);
        rsp_done  = (state == S_FINISH);
        cs_oe     = run;
        sck_oe    = run;
        cs_o      = cur_write && in_cmd;
        sck_o     = (state == S_CMD_HI) || (state == S_TURN_HI) ||
                    (state == S_RD_HI)  || (state == S_XTRA_HI);
        sd_oe     = run && (in_cmd || cur_write);
        sd_o      = sd_oe && (state != S_LEAD) && sh[FRAME_W-1];
    end

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(cs_oe || sck_oe || sd_oe));

    assert_read_cs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe && !cur_write) |-> !cs_o);

    assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_LO || state == S_RD_HI || state == S_TURN_HI) |-> !sd_oe);

    assert_sck_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe && $past(sck_oe) && (sck_o != $past(sck_o))) |-> $past(tick));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> ($stable(cur_lsb) && $stable(cur_write) && $stable(cur_table)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

// File: tb/swreg_serial_master_tb.sv
module swreg_serial_master_tb;
    localparam int CLK_MHZ = 2;
    localparam int PH = (CLK_MHZ * 3000 + 999) / 1000;
    localparam int SU = (CLK_MHZ * 1000 + 999) / 1000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_table = 1'b0;
    logic [7:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic req_ready, rsp_done;
    logic [31:0] rsp_rdata;
    logic cs_o, cs_oe, sck_o, sck_oe, sd_o, sd_oe, sd_i;

    swreg_serial_master #(.CLK_MHZ(CLK_MHZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_table(req_table), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .cs_o(cs_o), .cs_oe(cs_oe), .sck_o(sck_o), .sck_oe(sck_oe),
        .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
    );

    int checks = 0, fails = 0;

    // wire monitor, sampled on the falling system edge
    int rises = 0, cs_hi = 0, rel = 0, tbad = 0, plen = 0, sd_since = 0;
    logic [127:0] cap = '0;
    logic sck_prev = 1'b0, sd_prev = 1'b0, sdoe_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sck_oe && sck_o && !sck_prev) begin
                rises <= rises + 1;
                cap   <= {cap[126:0], sd_oe ? sd_o : 1'b0};
                if (cs_o) cs_hi <= cs_hi + 1;
                if (!sd_oe) rel <= rel + 1;
                if (sd_oe && (sd_since + 1 < SU)) tbad <= tbad + 1;
            end
            if (!sck_oe) plen <= 0;
            else if (sck_o != sck_prev) begin
                if (plen < PH) tbad <= tbad + 1;
                plen <= 1;
            end else plen <= plen + 1;
            if (!sdoe_prev || sd_o != sd_prev) sd_since <= 0;
            else sd_since <= sd_since + 1;
        end
        sck_prev  <= sck_o;
        sd_prev   <= sd_o;
        sdoe_prev <= sd_oe;
    end

    // device model: presents response bits before data rising edges
    int rd_base = 0;
    logic [31:0] resp = '0;
    always_comb begin
        int k;
        k = rises - rd_base;
        if (k >= 48 && k < 80) sd_i = resp[79 - k];
        else sd_i = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start_req(input bit wr, input bit tbl, input logic [7:0] a,
                             input logic [15:0] wd);
        @(negedge clk);
        req_write = wr; req_table = tbl; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic [31:0] rd, output bit width_ok);
        int n;
        n = 0;
        while (!rsp_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) chk(0, "R10 done timeout", 64'(n), 64'(0));
        rd = rsp_rdata;
        @(negedge clk);
        width_ok = !rsp_done;
    endtask

    task automatic eval(input bit wr, input bit tbl, input logic [7:0] a,
                        input logic [15:0] wd, input int b_r, input int b_cs,
                        input int b_rel, input int b_t, input logic [31:0] rd,
                        input bit wok);
        logic [26:0] wexp;
        logic [45:0] rexp;
        logic [31:0] dexp;
        int nr;
        nr = rises - b_r;
        chk(tbad == b_t, "R8 phase/setup timing", 64'(tbad - b_t), 64'(0));
        chk(wok, "R10 done width", 64'(0), 64'(1));
        if (wr) begin
            wexp = {1'b1, 2'b01, a, wd};
            chk(nr == 29, "R3 write edge count", 64'(nr), 64'(29));
            chk(cap[28:2] == wexp, "R2 write frame", 64'(cap[28:2]), 64'(wexp));
            chk(cs_hi - b_cs == 27, "R3 cs high edges", 64'(cs_hi - b_cs), 64'(27));
            chk(rel == b_rel, "R3 data driven", 64'(rel - b_rel), 64'(0));
            chk(rd == 32'h0, "R10 write rdata", 64'(rd), 64'(0));
        end else begin
            rexp = {32'hFFFF_FFFF, 4'b0110, tbl, a[6:0], 2'b00};
            if (tbl) dexp = resp;
            else if (a[0]) dexp = {16'h0, resp[31:16]};
            else dexp = {16'h0, resp[15:0]};
            chk(nr == 82, "R5 read edge count", 64'(nr), 64'(82));
            chk(cap[81:36] == rexp, "R4 read command", 64'(cap[81:36]), 64'(rexp));
            chk(cs_hi == b_cs, "R4 cs low on read", 64'(cs_hi - b_cs), 64'(0));
            chk(rel - b_rel == 36, "R5 released edges", 64'(rel - b_rel), 64'(36));
            if (tbl) chk(rd == dexp, "R7 counter word", 64'(rd), 64'(dexp));
            else     chk(rd == dexp, "R6 half select", 64'(rd), 64'(dexp));
        end
    endtask

    task automatic run_txn(input bit wr, input bit tbl, input logic [7:0] a,
                           input logic [15:0] wd, input logic [31:0] rw);
        int b_r, b_cs, b_rel, b_t;
        logic [31:0] rd;
        bit wok;
        @(negedge clk);
        b_r = rises; b_cs = cs_hi; b_rel = rel; b_t = tbad;
        rd_base = rises; resp = rw;
        start_req(wr, tbl, a, wd);
        wait_done(rd, wok);
        eval(wr, tbl, a, wd, b_r, b_cs, b_rel, b_t, rd, wok);
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int b_r, b_cs, b_rel, b_t, busy_acc;
        logic [31:0] rd;
        bit wok;
        repeat (3) @(negedge clk);
        chk(req_ready && !cs_oe && !sck_oe && !sd_oe, "R1 in reset",
            64'({req_ready, cs_oe, sck_oe, sd_oe}), 64'(4'b1000));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(req_ready && !cs_oe && !sck_oe && !sd_oe, "R1 after reset",
            64'({req_ready, cs_oe, sck_oe, sd_oe}), 64'(4'b1000));

        // write sweep
        for (int i = 0; i < 8; i++) begin
            logic [7:0] a;
            a = (i == 7) ? 8'hFF : 8'((i * 37) ^ (i << 6));
            run_txn(1'b1, 1'b0, a, 16'((i * 16'h2F1D) ^ 16'hA55A), 32'h0);
        end
        // 16-bit table reads, both halves
        for (int i = 0; i < 10; i++) begin
            logic [7:0] a;
            a = (i < 8) ? 8'(i) : ((i == 8) ? 8'h7F : 8'hC2);
            run_txn(1'b0, 1'b0, a, 16'h0, 32'((i + 1) * 32'h1357_9BDF) ^ 32'hF0C3_3C0F);
        end
        // counter table reads
        for (int i = 0; i < 4; i++) begin
            logic [7:0] a;
            a = 8'((i * 21) + 1);
            run_txn(1'b0, 1'b1, a, 16'h0, 32'h8000_0001 ^ 32'(i * 32'h0F1E_2D3C));
        end

        // R9: request held across a write's done pulse
        @(negedge clk);
        b_r = rises; b_cs = cs_hi; b_rel = rel; b_t = tbad;
        start_req(1'b1, 1'b0, 8'h3C, 16'hBEEF);
        repeat (40) @(negedge clk);
        req_write = 1'b0; req_table = 1'b1; req_addr = 8'h55; req_wdata = 16'h1234;
        req_valid = 1'b1;
        busy_acc = 0;
        while (!rsp_done) begin
            if (req_ready) busy_acc++;
            @(negedge clk);
        end
        chk(busy_acc == 0, "R9 ready low while busy", 64'(busy_acc), 64'(0));
        wait_done(rd, wok);
        eval(1'b1, 1'b0, 8'h3C, 16'hBEEF, b_r, b_cs, b_rel, b_t, rd, wok);
        b_r = rises; b_cs = cs_hi; b_rel = rel; b_t = tbad;
        rd_base = rises; resp = 32'hC0DE_F00D;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(rd, wok);
        eval(1'b0, 1'b1, 8'h55, 16'h0, b_r, b_cs, b_rel, b_t, rd, wok);

        // R9: short pulse during a read leaves no trace
        @(negedge clk);
        b_r = rises; b_cs = cs_hi; b_rel = rel; b_t = tbad;
        rd_base = rises; resp = 32'h6A5F_0921;
        start_req(1'b0, 1'b0, 8'h11, 16'h0);
        repeat (100) @(negedge clk);
        req_write = 1'b1; req_addr = 8'h99; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_done(rd, wok);
        eval(1'b0, 1'b0, 8'h11, 16'h0, b_r, b_cs, b_rel, b_t, rd, wok);
        b_r = rises;
        repeat (100) @(negedge clk);
        chk(rises == b_r, "R9 no stray frame", 64'(rises - b_r), 64'(0));
        chk(req_ready && !cs_oe && !sck_oe && !sd_oe, "R1 idle after runs",
            64'({req_ready, cs_oe, sck_oe, sd_oe}), 64'(4'b1000));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule